// File: doc/BRIEF.md
# Receive Idle Timeout Timer

This block watches a serial receiver for silence. Once received data has been stored, it counts whole character times, and it restarts the count each time another character lands. If the programmed number of character times passes with no new data, it declares a receive timeout. The timeout sets a sticky status flag and sends a one-cycle pulse that sets the receive interrupt source. A timeout fires only when data is waiting, or when software has asked for timeouts even with an empty buffer. The timer is dropped when the buffer reaches its interrupt trigger level, because that interrupt already reports the data.

The baud logic supplies the character-time tick. One character time is (data bits + stop bits + 1) bit periods. The register file supplies the enable, the length and the empty-buffer enable, and it forwards writes to the status flag. The storage and the deserializer are outside this block.

Top module: `rx_idle_timer`

## Requirements
- R1: After reset, `timeoutFlag` and `rxIntSet` are both low, and the timer is not armed.
- R2: While `toEnable` is low, the timer is cleared and disarmed, and no timeout occurs. After `toEnable` goes high again, the count starts only once new data is stored.
- R3: After a `rxStore` pulse and with no further data, the timeout occurs on the L-th following `charTick`, where L is `toLength`. `rxIntSet` is high, and `timeoutFlag` becomes set, in the cycle after the clock edge that samples that tick.
- R4: Each `rxStore` pulse resets the elapsed count to zero, so L fresh ticks are needed after the most recent store.
- R5: At expiry, nothing is signalled unless `dataReady` or `emptyEn` is high. Either way, the timer disarms at expiry.
- R6: A `trigHit` pulse cancels a running timer, and no timeout follows until the next store. `trigHit` takes priority over a `rxStore` in the same cycle.
- R7: A status write (`statusWr` high) with `statusBit` = 1 clears `timeoutFlag`. With `statusBit` = 0, the flag is left unchanged.
- R8: When `toLength` is 0, no timeout pulse is produced, however many ticks pass.
- R9: `rxIntSet` is never high for two cycles in a row.
- R10: If a timeout fires in the same cycle as a clearing status write, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| toEnable | input | 1 | Timeout enable control field |
| toLength | input | LEN_W | Timeout length in character times |
| emptyEn | input | 1 | Allow a timeout with an empty buffer |
| dataReady | input | 1 | Receive data is pending |
| rxStore | input | 1 | Pulse: a character was stored |
| trigHit | input | 1 | Pulse: buffer reached its trigger level |
| charTick | input | 1 | One-cycle pulse per character time |
| statusWr | input | 1 | Status register write strobe |
| statusBit | input | 1 | Data on the timeout status bit of that write |
| timeoutFlag | output | 1 | Sticky receive-timeout status |
| rxIntSet | output | 1 | Pulse that sets the receive interrupt source |

## Verification
Every result is registered once. An input applied before a rising edge shows up at the outputs just after that edge, so the outputs are due one cycle after the stimulus. The bench drives inputs on the falling edge. A behavioural model steps on the rising edge from the same inputs, and the outputs are compared with it on the next falling edge, every cycle. Directed phases cover restart, cancellation, gating, zero length, disable and the set-against-clear race, and each phase tags its checks with its requirement.

// File: rtl/rx_idle_timer_pkg.sv
package rx_idle_timer_pkg;
  typedef struct packed {
    logic clearCnt;
    logic advance;
  } ctlStrobe_t;
endpackage

// File: rtl/rx_idle_dp.sv
module rx_idle_dp
  import rx_idle_timer_pkg::*;
#(
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobe_t       strobe,
  input  logic [LEN_W-1:0] toLength,
  output logic             lastTick
);
  localparam logic [LEN_W:0] CNT_MAX = {1'b0, {LEN_W{1'b1}}};

  logic [LEN_W-1:0] elapsed;
  logic [LEN_W:0]   nextCount;

  assign nextCount = {1'b0, elapsed} + 1'b1;
  assign lastTick  = (toLength != '0) && (nextCount >= {1'b0, toLength});

  always_ff @(posedge clk) begin
    if (!rstN || strobe.clearCnt) begin
      elapsed <= '0;
    end else if (strobe.advance && ({1'b0, elapsed} != CNT_MAX)) begin
      elapsed <= nextCount[LEN_W-1:0];
    end
  end

  p_zero_len_never_last_r8: assert property (@(posedge clk) disable iff (!rstN)
    (toLength == '0) |-> !lastTick);
endmodule

// File: rtl/rx_idle_ctl.sv
module rx_idle_ctl
  import rx_idle_timer_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       toEnable,
  input  logic       emptyEn,
  input  logic       dataReady,
  input  logic       rxStore,
  input  logic       trigHit,
  input  logic       charTick,
  input  logic       statusWr,
  input  logic       statusBit,
  input  logic       lastTick,
  output ctlStrobe_t strobe,
  output logic       timeoutFlag,
  output logic       rxIntSet
);
  logic armed;
  logic cancel, restart, expire, fire;

  always_comb begin
    cancel  = !toEnable || trigHit;
    restart = !cancel && rxStore;
    strobe.advance  = !cancel && !rxStore && armed && charTick;
    expire  = strobe.advance && lastTick;
    fire    = expire && (dataReady || emptyEn);
    strobe.clearCnt = cancel || restart || expire;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      armed       <= 1'b0;
      timeoutFlag <= 1'b0;
      rxIntSet    <= 1'b0;
    end else begin
      if (cancel || expire) armed <= 1'b0;
      else if (restart)     armed <= 1'b1;
      if (fire)                        timeoutFlag <= 1'b1;
      else if (statusWr && statusBit)  timeoutFlag <= 1'b0;
      rxIntSet <= fire;
    end
  end

  p_pulse_single_r9: assert property (@(posedge clk) disable iff (!rstN)
    rxIntSet |=> !rxIntSet);
  p_flag_with_pulse_r3: assert property (@(posedge clk) disable iff (!rstN)
    rxIntSet |-> timeoutFlag);
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    !armed |=> !rxIntSet);
  p_cancel_quiet_r6: assert property (@(posedge clk) disable iff (!rstN)
    trigHit |=> !rxIntSet);
  p_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    (statusWr && statusBit && !rxIntSet) |=> (!timeoutFlag || rxIntSet));
endmodule

// File: rtl/rx_idle_timer.sv
module rx_idle_timer
  import rx_idle_timer_pkg::*;
#(
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             toEnable,
  input  logic [LEN_W-1:0] toLength,
  input  logic             emptyEn,
  input  logic             dataReady,
  input  logic             rxStore,
  input  logic             trigHit,
  input  logic             charTick,
  input  logic             statusWr,
  input  logic             statusBit,
  output logic             timeoutFlag,
  output logic             rxIntSet
);
  ctlStrobe_t strobe;
  logic       lastTick;

  rx_idle_ctl ctl_i (
    .clk(clk), .rstN(rstN), .toEnable(toEnable), .emptyEn(emptyEn),
    .dataReady(dataReady), .rxStore(rxStore), .trigHit(trigHit),
    .charTick(charTick), .statusWr(statusWr), .statusBit(statusBit),
    .lastTick(lastTick), .strobe(strobe), .timeoutFlag(timeoutFlag),
    .rxIntSet(rxIntSet)
  );

  rx_idle_dp #(.LEN_W(LEN_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .toLength(toLength),
    .lastTick(lastTick)
  );
endmodule

// File: tb/rx_idle_timer_tb_top.sv
module rx_idle_timer_tb_top;
  localparam int LEN_W = 4;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic toEnable = 1'b0, emptyEn = 1'b0, dataReady = 1'b0;
  logic rxStore = 1'b0, trigHit = 1'b0, charTick = 1'b0;
  logic statusWr = 1'b0, statusBit = 1'b0;
  logic [LEN_W-1:0] toLength = '0;
  logic timeoutFlag, rxIntSet;

  int total = 0, bad = 0, pulses = 0;
  string phase = "R1";

  // reference model state
  bit mArmed = 0, mFlag = 0, mPulse = 0;
  int mCount = 0;

  always #4 clk = ~clk;

  rx_idle_timer #(.LEN_W(LEN_W)) dut_i (.*);

  always @(posedge clk) begin
    if (!rstN) begin
      mArmed = 0; mFlag = 0; mPulse = 0; mCount = 0;
    end else begin
      bit fire;
      fire = 0;
      if (!toEnable || trigHit) begin
        mArmed = 0; mCount = 0;
      end else if (rxStore) begin
        mArmed = 1; mCount = 0;
      end else if (mArmed && charTick) begin
        if (toLength != 0 && mCount + 1 >= toLength) begin
          mArmed = 0; mCount = 0;
          fire = dataReady || emptyEn;
        end else if (mCount < 15) begin
          mCount = mCount + 1;
        end
      end
      if (fire) mFlag = 1;
      else if (statusWr && statusBit) mFlag = 0;
      mPulse = fire;
    end
  end

  always @(negedge clk) begin
    total++;
    if (timeoutFlag !== mFlag || rxIntSet !== mPulse) begin
      bad++;
      $display("FAIL %s: flag=%b pulse=%b expected flag=%b pulse=%b",
               phase, timeoutFlag, rxIntSet, mFlag, mPulse);
    end
    if (rxIntSet === 1'b1) pulses++;
  end

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask
  task automatic store();
    rxStore = 1; @(negedge clk); rxStore = 0;
  endtask
  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      charTick = 1; @(negedge clk); charTick = 0; cyc(2);
    end
  endtask
  task automatic clrWrite(bit b);
    statusWr = 1; statusBit = b; @(negedge clk); statusWr = 0; statusBit = 0;
  endtask
  task automatic expectPulses(int exp, string tag);
    total++;
    if (pulses != exp) begin
      bad++;
      $display("FAIL %s: pulse count=%0d expected %0d", tag, pulses, exp);
    end
  endtask

  initial begin
    fork
      begin
        cyc(3); rstN = 1; cyc(2);
        phase = "R1"; expectPulses(0, "R1");
        // R3: basic expiry
        phase = "R3"; toEnable = 1; toLength = 3; dataReady = 1;
        store(); ticks(3); cyc(2); expectPulses(1, "R3");
        // R7: write 0 keeps, write 1 clears
        phase = "R7"; clrWrite(0); cyc(1); clrWrite(1); cyc(2);
        // R4: restart
        phase = "R4"; pulses = 0;
        store(); ticks(2); store(); ticks(2); expectPulses(0, "R4");
        ticks(1); cyc(1); expectPulses(1, "R4");
        // R5: gating
        phase = "R5"; pulses = 0; dataReady = 0; emptyEn = 0;
        store(); ticks(4); expectPulses(0, "R5");
        emptyEn = 1; store(); ticks(3); cyc(1); expectPulses(1, "R5");
        emptyEn = 0; dataReady = 1;
        // R6: cancel, and priority over store
        phase = "R6"; pulses = 0;
        store(); ticks(1); trigHit = 1; @(negedge clk); trigHit = 0;
        ticks(5); expectPulses(0, "R6");
        rxStore = 1; trigHit = 1; @(negedge clk); rxStore = 0; trigHit = 0;
        ticks(5); expectPulses(0, "R6");
        // R8: zero length
        phase = "R8"; toLength = 0; store(); ticks(20); expectPulses(0, "R8");
        // R2: disable
        phase = "R2"; toLength = 2; store(); ticks(1); toEnable = 0; cyc(1);
        ticks(4); toEnable = 1; ticks(4); expectPulses(0, "R2");
        // R10: set wins over clear
        phase = "R10"; toLength = 1; clrWrite(1); store();
        charTick = 1; statusWr = 1; statusBit = 1; @(negedge clk);
        charTick = 0; statusWr = 0; statusBit = 0; cyc(2);
        total++;
        if (timeoutFlag !== 1'b1) begin
          bad++; $display("FAIL R10: flag=%b expected 1", timeoutFlag);
        end
        // R9: back-to-back length 1 expiries
        phase = "R9"; pulses = 0;
        for (int k = 0; k < 4; k++) begin store(); ticks(1); end
        cyc(2); expectPulses(4, "R9");
      end
      begin
        cyc(5000);
        bad++; total++;
        $display("FAIL watchdog: run did not finish, expected completion");
      end
    join_any
    disable fork;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule